// File: doc/BRIEF.md
# Keyed Configuration Item Register Port

This block is a memory-mapped slave through which boot software reads a set of read-mostly configuration items. Software writes a 16-bit key into a selector window and then pulls the chosen item out of a data window, one to eight bytes per access. A byte cursor kept for the current selection advances on every byte consumed. Bytes are packed most-significant first. Once the item runs out, the read returns zero fill.

The item contents are fixed at build time through parameters. Two banks exist: a common bank and a platform-local bank. Each bank has 32 fixed keys and 32 file slots. A third window returns a constant 64-bit signature so that software can confirm the block is present. Every request gets a response on the next clock, which carries either read data or an error flag.

Top module: `cfgport_top`

## Requirements
- R1: After reset the selection is key 0, with its cursor at byte 0. In that state, a 4-byte data read returns 0x51454D55 (the ASCII bytes Q, E, M, U).
- R2: A request whose offset is 24 or higher gets an error response and changes no state.
- R3: A request whose size is not 1, 2, 4 or 8 bytes gets an error response, returns zero data and changes no state.
- R4: A write to the selector window (offsets 8 to 15) loads the key from write-data bits 15:0 and always returns the cursor to byte 0. A read of the selector window returns 0.
- R5: Key bit 15 picks the platform-local bank. Key bit 14 is a write-channel flag that plays no part in the lookup. The item index is the key with both bits cleared.
- R6: If the index is 64 or more, the selection becomes the invalid key 0xFFFF. Every data read then returns 0.
- R7: An N-byte data read (offsets 0 to 7) returns item bytes with the first byte in bits 8N-1:8N-8. The cursor advances by the number of bytes consumed.
- R8: If the item ends inside an N-byte read, the bytes that are missing are the low-order bytes of the result, and they read as zero.
- R9: A data read of an empty item, an exhausted item or the invalid key returns 0 and leaves the cursor unchanged.
- R10: Writes to the data window are accepted without error and have no effect.
- R11: Reads at offsets 16 to 23 return bytes of 0x51454D5520434647, indexed from its most significant byte by (offset - 16). An access that would run past offset 23 is rejected with an error. Writes that fit inside this window are accepted without effect.
- R12: The response strobe is high exactly in the cycle after each request.
- R13: The preloaded contents are as follows. Key 1 holds the bytes 0x03, 0x00. Common key 32 holds 11 bytes of value 0xC0 + i. Local-bank key 2 holds 3 bytes of value 0x70 + i. All other items are empty.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request strobe, one cycle per access |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 8 | Byte offset within the block |
| req_size | input | 4 | Access size in bytes |
| req_wdata | input | 64 | Write value, right-aligned |
| rsp_ready | output | 1 | Response strobe, the cycle after a request |
| rsp_err | output | 1 | Error response |
| rsp_rdata | output | 64 | Read value, right-aligned, big-endian packed |

## Verification
The hardest case to reach is the cursor sitting partway through an item when a read straddles the item's end. To get there, the stimulus must first advance the cursor with a run of smaller reads. The next wide read must then show both the zero-filled low bytes and the cursor stopping at the item length. After that, a further read must return zero without moving the cursor. The bench builds this up on the 11-byte file item: it re-selects the item between runs and interleaves ignored data writes and rejected sizes, and each time it confirms the cursor position by the next bytes read back.

// File: rtl/cfgport_pkg.sv
package cfgport_pkg;

  localparam int KEY_W = 16;
  localparam logic [KEY_W-1:0] KEY_INVALID = 16'hFFFF;
  localparam int KEY_BANK_BIT = 15;
  localparam logic [KEY_W-1:0] KEY_INDEX_MASK = 16'h3FFF;
  localparam logic [63:0] SIGNATURE = 64'h51454D5520434647;

  typedef enum logic [1:0] {
    WIN_DATA = 2'd0,
    WIN_SEL  = 2'd1,
    WIN_SIG  = 2'd2,
    WIN_NONE = 2'd3
  } win_e;

  // Legal access widths in bytes.
  function automatic logic size_legal(input logic [3:0] n);
    return (n == 4'd1) || (n == 4'd2) || (n == 4'd4) || (n == 4'd8);
  endfunction

  // Index field of a key, bank and write-flag bits removed.
  function automatic logic [KEY_W-1:0] key_index(input logic [KEY_W-1:0] key);
    return key & KEY_INDEX_MASK;
  endfunction

  // Bytes a read of n takes from an item of length len at cursor off.
  function automatic int take_count(input int len, input int off, input int n);
    int rem;
    if (off >= len) return 0;
    rem = len - off;
    return (rem < n) ? rem : n;
  endfunction

  // n bytes of the signature starting at byte off (0 = most significant).
  function automatic logic [63:0] sig_slice(input int off, input int n);
    logic [63:0] v;
    v = SIGNATURE >> ((8 - off - n) * 8);
    if (n < 8) v = v & ((64'd1 << (n * 8)) - 64'd1);
    return v;
  endfunction

endpackage

// File: rtl/cfgport_store.sv
module cfgport_store
  import cfgport_pkg::*;
#(
  parameter int ITEM_BYTES = 16,
  parameter int FILE_BASE  = 32,
  parameter int FILE_LEN   = 11,
  parameter int ARCH_KEY   = 2,
  parameter int ARCH_LEN   = 3,
  parameter logic [15:0] VERSION = 16'h0003,
  parameter int OFF_W      = $clog2(ITEM_BYTES + 1)
) (
  input  logic             bank,
  input  logic [13:0]      idx,
  input  logic [OFF_W-1:0] base,
  output logic [OFF_W-1:0] item_len,
  output logic [63:0]      win
);

  localparam logic [31:0] MAGIC     = 32'h51454D55;
  localparam logic [7:0]  FILE_SEED = 8'hC0;
  localparam logic [7:0]  ARCH_SEED = 8'h70;

  function automatic int len_of(input logic b, input int i);
    if (!b && i == 0) return 4;
    if (!b && i == 1) return 2;
    if (!b && i == FILE_BASE) return FILE_LEN;
    if (b && i == ARCH_KEY) return ARCH_LEN;
    return 0;
  endfunction

  function automatic logic [7:0] byte_of(input logic b, input int i, input int off);
    if (off >= len_of(b, i)) return 8'h00;
    if (!b && i == 0) return MAGIC[(3 - off) * 8 +: 8];
    if (!b && i == 1) return VERSION[off * 8 +: 8];
    if (!b && i == FILE_BASE) return FILE_SEED + 8'(off);
    if (b && i == ARCH_KEY) return ARCH_SEED + 8'(off);
    return 8'h00;
  endfunction

  assign item_len = OFF_W'(len_of(bank, int'(idx)));

  for (genvar j = 0; j < 8; j++) begin : g_win
    assign win[j*8 +: 8] = byte_of(bank, int'(idx), int'(base) + j);
  end

endmodule

// File: rtl/cfgport_cursor.sv
module cfgport_cursor
  import cfgport_pkg::*;
#(
  parameter int ITEM_COUNT = 64,
  parameter int OFF_W      = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             sel_we,
  input  logic [KEY_W-1:0] sel_in,
  input  logic             rd_en,
  input  logic [3:0]       rd_n,
  input  logic [OFF_W-1:0] item_len,
  input  logic [63:0]      win,
  output logic [KEY_W-1:0] cur_key,
  output logic [OFF_W-1:0] cur_off,
  output logic             key_valid,
  output logic [63:0]      rd_value
);

  int avail;
  int n_i;
  logic [KEY_W-1:0] next_key;

  assign key_valid = (cur_key != KEY_INVALID);
  assign next_key  = (int'(key_index(sel_in)) >= ITEM_COUNT) ? KEY_INVALID : sel_in;

  always_comb begin
    n_i      = int'(rd_n);
    avail    = key_valid ? take_count(int'(item_len), int'(cur_off), n_i) : 0;
    rd_value = '0;
    for (int i = 0; i < 8; i++) begin
      if (i < avail) rd_value[(n_i - 1 - i) * 8 +: 8] = win[i*8 +: 8];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cur_key <= '0;
      cur_off <= '0;
    end else if (sel_we) begin
      cur_key <= next_key;
      cur_off <= '0;
    end else if (rd_en) begin
      cur_off <= cur_off + OFF_W'(avail);
    end
  end

  a_r4_select_rewinds: assert property (@(posedge clk) disable iff (!rst_n)
    sel_we |=> (cur_off == '0));

  a_r9_stall_on_invalid: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && !key_valid) |=> $stable(cur_off));

  a_r7_cursor_in_item: assert property (@(posedge clk) disable iff (!rst_n)
    key_valid |-> (cur_off <= item_len));

  a_r6_only_legal_keys: assert property (@(posedge clk) disable iff (!rst_n)
    (cur_key == KEY_INVALID) || (int'(key_index(cur_key)) < ITEM_COUNT));

endmodule

// File: rtl/cfgport_top.sv
module cfgport_top
  import cfgport_pkg::*;
#(
  parameter int ADDR_W     = 8,
  parameter int ITEM_BYTES = 16,
  parameter int FIXED_KEYS = 32,
  parameter int FILE_SLOTS = 32,
  parameter int FILE_LEN   = 11,
  parameter int ARCH_KEY   = 2,
  parameter int ARCH_LEN   = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [3:0]        req_size,
  input  logic [63:0]       req_wdata,
  output logic              rsp_ready,
  output logic              rsp_err,
  output logic [63:0]       rsp_rdata
);

  localparam int ITEM_COUNT = FIXED_KEYS + FILE_SLOTS;
  localparam int OFF_W      = $clog2(ITEM_BYTES + 1);
  localparam int DATA_END   = 8;
  localparam int SEL_END    = 16;
  localparam int SIG_END    = 24;

  win_e             win;
  logic             size_ok;
  logic             sig_fit;
  logic             acc_err;
  logic             sel_event;
  logic             rd_event;
  int               sig_off;
  logic [KEY_W-1:0] cur_key;
  logic [OFF_W-1:0] cur_off;
  logic             key_valid;
  logic [OFF_W-1:0] item_len;
  logic [63:0]      item_win;
  logic [63:0]      rd_value;
  logic [63:0]      read_mux;

  always_comb begin
    if (int'(req_addr) < DATA_END)     win = WIN_DATA;
    else if (int'(req_addr) < SEL_END) win = WIN_SEL;
    else if (int'(req_addr) < SIG_END) win = WIN_SIG;
    else                               win = WIN_NONE;
  end

  assign size_ok   = size_legal(req_size);
  assign sig_off   = int'(req_addr) - SEL_END;
  assign sig_fit   = (sig_off + int'(req_size)) <= 8;
  assign acc_err   = !size_ok || (win == WIN_NONE) || ((win == WIN_SIG) && !sig_fit);
  assign sel_event = req_valid && req_write && (win == WIN_SEL) && !acc_err;
  assign rd_event  = req_valid && !req_write && (win == WIN_DATA) && !acc_err;

  cfgport_store #(
    .ITEM_BYTES(ITEM_BYTES),
    .FILE_BASE (FIXED_KEYS),
    .FILE_LEN  (FILE_LEN),
    .ARCH_KEY  (ARCH_KEY),
    .ARCH_LEN  (ARCH_LEN),
    .OFF_W     (OFF_W)
  ) u_store (
    .bank    (cur_key[KEY_BANK_BIT]),
    .idx     (cur_key[13:0]),
    .base    (cur_off),
    .item_len(item_len),
    .win     (item_win)
  );

  cfgport_cursor #(
    .ITEM_COUNT(ITEM_COUNT),
    .OFF_W     (OFF_W)
  ) u_cursor (
    .clk      (clk),
    .rst_n    (rst_n),
    .sel_we   (sel_event),
    .sel_in   (req_wdata[KEY_W-1:0]),
    .rd_en    (rd_event),
    .rd_n     (req_size),
    .item_len (item_len),
    .win      (item_win),
    .cur_key  (cur_key),
    .cur_off  (cur_off),
    .key_valid(key_valid),
    .rd_value (rd_value)
  );

  always_comb begin
    case (win)
      WIN_DATA: read_mux = rd_value;
      WIN_SIG:  read_mux = sig_slice(sig_off, int'(req_size));
      default:  read_mux = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_ready <= 1'b0;
      rsp_err   <= 1'b0;
      rsp_rdata <= '0;
    end else begin
      rsp_ready <= req_valid;
      rsp_err   <= req_valid && acc_err;
      rsp_rdata <= (req_valid && !req_write && !acc_err) ? read_mux : '0;
    end
  end

  a_r12_rsp_follows_req: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> rsp_ready);

  a_r12_no_spurious_rsp: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |=> !rsp_ready);

  a_r2_out_of_range: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && int'(req_addr) >= SIG_END) |=> (rsp_err && rsp_rdata == '0));

  a_r3_bad_size_inert: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !size_legal(req_size)) |=> (rsp_err && $stable(cur_key) && $stable(cur_off)));

  a_r11_full_signature: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !req_write && int'(req_addr) == SEL_END && req_size == 4'd8)
      |=> (rsp_rdata == SIGNATURE));

  a_r6_invalid_reads_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_event && !key_valid) |=> (rsp_rdata == '0));

endmodule

// File: tb/test_cfgport_top.sv
module test_cfgport_top;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_write = 1'b0;
  logic [7:0]  req_addr = '0;
  logic [3:0]  req_size = '0;
  logic [63:0] req_wdata = '0;
  logic        rsp_ready;
  logic        rsp_err;
  logic [63:0] rsp_rdata;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  // behavioural reference state
  logic [15:0] m_key = 16'h0000;
  int          m_off = 0;
  logic        m_ready = 1'b0;

  always #10 clk = ~clk;

  cfgport_top i_cfgport_top (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
    .req_addr(req_addr), .req_size(req_size), .req_wdata(req_wdata),
    .rsp_ready(rsp_ready), .rsp_err(rsp_err), .rsp_rdata(rsp_rdata)
  );

  function automatic int ref_len(input logic [15:0] k);
    int ix = int'(k & 16'h3FFF);
    if (k == 16'hFFFF) return 0;
    if (!k[15]) begin
      if (ix == 0) return 4;
      if (ix == 1) return 2;
      if (ix == 32) return 11;
    end else if (ix == 2) return 3;
    return 0;
  endfunction

  function automatic logic [7:0] ref_byte(input logic [15:0] k, input int off);
    string magic = "QEMU";
    int ix = int'(k & 16'h3FFF);
    if (!k[15] && ix == 0) return magic[off];
    if (!k[15] && ix == 1) return (off == 0) ? 8'h03 : 8'h00;
    if (!k[15] && ix == 32) return 8'(192 + off);
    return 8'(112 + off);
  endfunction

  task automatic check(input string tag, input logic [63:0] got, input logic [63:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  // R12: the response strobe is compared on every clock
  always @(posedge clk) m_ready <= rst_n ? req_valid : 1'b0;
  always @(negedge clk) if (rst_n && !done) check("R12 rsp_ready", 64'(rsp_ready), 64'(m_ready));

  task automatic access(input bit w, input int addr, input int sz, input logic [63:0] wd,
                        input string tag, output logic [63:0] got);
    logic        e_err;
    logic [63:0] e_dat;
    int          cnt;
    e_err = !(sz == 1 || sz == 2 || sz == 4 || sz == 8) || addr >= 24 ||
            (addr >= 16 && (addr - 16 + sz) > 8);
    e_dat = '0;
    if (!e_err) begin
      if (addr < 8) begin
        if (!w && m_key != 16'hFFFF && m_off < ref_len(m_key)) begin
          cnt = 0;
          while (cnt < sz && m_off < ref_len(m_key)) begin
            e_dat = (e_dat << 8) | 64'(ref_byte(m_key, m_off));
            m_off++;
            cnt++;
          end
          e_dat = e_dat << (8 * (sz - cnt));
        end
      end else if (addr < 16) begin
        if (w) begin
          m_key = (int'(wd[15:0] & 16'h3FFF) >= 64) ? 16'hFFFF : wd[15:0];
          m_off = 0;
        end
      end else if (!w) begin
        e_dat = (64'h51454D5520434647 << ((addr - 16) * 8)) >> ((8 - sz) * 8);
      end
    end
    req_valid = 1'b1;
    req_write = w;
    req_addr  = 8'(addr);
    req_size  = 4'(sz);
    req_wdata = wd;
    @(negedge clk);
    req_valid = 1'b0;
    got = rsp_rdata;
    check({tag, " err"}, 64'(rsp_err), 64'(e_err));
    check({tag, " data"}, rsp_rdata, e_dat);
  endtask

  task automatic sel(input logic [15:0] k, input string tag);
    logic [63:0] g;
    access(1'b1, 8, 2, 64'(k), tag, g);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    checks++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    logic [63:0] g;
    repeat (3) @(negedge clk);
    check("R1 reset rsp_ready", 64'(rsp_ready), 64'd0);
    check("R1 reset rsp_err", 64'(rsp_err), 64'd0);
    rst_n = 1'b1;
    @(negedge clk);

    access(1'b0, 0, 4, 0, "R1 R7 signature item", g);
    check("R1 hand value", g, 64'h51454D55);
    access(1'b0, 0, 1, 0, "R9 exhausted", g);
    access(1'b0, 9, 2, 0, "R4 selector read", g);

    sel(16'h0000, "R4 select 0");
    access(1'b0, 2, 2, 0, "R7 two bytes", g);
    check("R7 hand value", g, 64'h5145);
    access(1'b0, 7, 1, 0, "R7 next byte", g);
    sel(16'h0000, "R4 reselect");
    access(1'b0, 0, 1, 0, "R4 rewind", g);
    check("R4 hand value", g, 64'h51);

    sel(16'h0001, "R13 version key");
    access(1'b0, 0, 4, 0, "R8 R13 version", g);
    check("R13 hand value", g, 64'h03000000);

    sel(16'h0020, "R13 file key");
    access(1'b0, 0, 2, 0, "R13 file head", g);
    access(1'b1, 3, 8, 64'hFFFF_FFFF_FFFF_FFFF, "R10 data write", g);
    access(1'b0, 0, 2, 0, "R10 cursor kept", g);
    check("R10 hand value", g, 64'hC2C3);
    access(1'b0, 0, 3, 0, "R3 size 3", g);
    access(1'b0, 0, 0, 0, "R3 size 0", g);
    access(1'b0, 0, 4, 0, "R3 cursor kept", g);
    check("R3 hand value", g, 64'hC4C5C6C7);
    access(1'b0, 0, 8, 0, "R8 straddle end", g);
    check("R8 hand value", g, 64'hC8C9CA0000000000);
    access(1'b0, 0, 2, 0, "R9 past end", g);

    sel(16'h8002, "R5 local bank");
    access(1'b0, 0, 4, 0, "R5 local item", g);
    check("R5 hand value", g, 64'h70717200);
    sel(16'h4020, "R5 write flag");
    access(1'b0, 0, 1, 0, "R5 flag ignored", g);
    check("R5 hand flag", g, 64'hC0);
    sel(16'hC002, "R5 both flags");
    access(1'b0, 0, 2, 0, "R5 both flags read", g);
    sel(16'h0002, "R13 empty common 2");
    access(1'b0, 0, 4, 0, "R9 empty item", g);

    sel(16'h0040, "R6 index 64");
    access(1'b0, 0, 8, 0, "R6 invalid read", g);
    sel(16'h3FFF, "R6 index max");
    access(1'b0, 0, 1, 0, "R6 invalid read 2", g);
    sel(16'h803F, "R9 last local slot");
    access(1'b0, 0, 8, 0, "R9 empty local", g);

    access(1'b0, 24, 4, 0, "R2 offset 24", g);
    access(1'b1, 200, 2, 64'h0020, "R2 far write", g);
    access(1'b0, 0, 1, 0, "R2 state kept", g);

    access(1'b0, 16, 8, 0, "R11 full signature", g);
    check("R11 hand value", g, 64'h51454D5520434647);
    access(1'b0, 20, 4, 0, "R11 low word", g);
    access(1'b0, 17, 1, 0, "R11 byte", g);
    access(1'b0, 22, 4, 0, "R11 overrun", g);
    access(1'b0, 23, 1, 0, "R11 last byte", g);
    access(1'b1, 16, 8, 64'h1234, "R11 write", g);
    sel(16'h0020, "R11 reselect");
    access(1'b0, 0, 1, 0, "R11 write inert", g);

    req_valid = 1'b1;
    req_addr  = 8'd0;
    req_size  = 4'd1;
    @(negedge clk);
    req_valid = 1'b0;
    m_off++;
    @(negedge clk);
    check("R12 idle after strobe", 64'(rsp_ready), 64'd0);

    rst_n = 1'b0;
    m_key = 16'h0000;
    m_off = 0;
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    access(1'b0, 0, 4, 0, "R1 after reset", g);
    check("R1 hand value 2", g, 64'h51454D55);

    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule